// File: doc/BRIEF.md
# Low-Power Lane Turnaround Controller

This block hands ownership of a bidirectional data lane from one side to the other while the lane is in low-power signalling. It runs in one of two roles, picked by which side currently owns the lane. The owning side runs the release role. It drives the request states, holds the bridge state (both wires low) for a fixed number of LP periods, and then stops driving. The non-owning side runs the acquire role. It watches the sampled line for the request, waits a bounded sure time, drives the bridge state itself for a longer fixed span, marks with one more request state and settles in the stop state as the new owner.

Every state period is a whole number of LP units. One LP unit lasts `lpxCycles` clock cycles, a programmable count that software derives from the 50 ns minimum LP period and the clock rate. The line is two bits wide in both directions. Bit 1 is the positive wire and bit 0 the negative wire, so stop = 2'b11, request = 2'b10, 2'b01 is the mirror state and bridge = 2'b00. `driveEn` tells the pad whether the output pair is driven. In the acquire role, any line state that does not fit the expected sequence ends the attempt with a one-cycle error pulse.

Top module: `lp_turnaround`

## Requirements
- R1: After reset the block is idle and owns the lane (default). Idle output is `lineOut` = 2'b11 with `done` and `error` at 0, and `driveEn` equals ownership. Whenever `driveEn` is 0, `lineOut` reads 2'b11.
- R2: A release accepted at a clock edge drives 2'b11 for L cycles and then 2'b10 for L cycles, where L = `lpxCycles`, with `driveEn` at 1 throughout.
- R3: The release role then drives the bridge 2'b00 for exactly 4·L cycles. After that, `driveEn` falls with `done` high for one cycle, and the side no longer owns the lane.
- R4: `startGive` is ignored unless the side owns the lane, and `startTake` is ignored unless it does not. Both are only looked at while idle. An ignored start leaves every output unchanged.
- R5: In the acquire role, `driveEn` stays 0 while the line shows 2'b11, then 2'b10, then 2'b00. The first cycle with `driveEn` = 1 comes exactly L cycles after the cycle in which 2'b00 was first sampled, so the sure wait lies between 1 and 2 LP units.
- R6: The acquire role drives 2'b00 for 5·L cycles, then 2'b10 for L cycles, then 2'b11 with `done` high for one cycle. It then stays idle, driving 2'b11 as owner.
- R7: The acquire role accepts up to 2·L consecutive samples of 2'b10. A (2·L+1)-th sample of 2'b10 is an error.
- R8: In the acquire role, a sample of 2'b01 or 2'b00 while waiting for the request, 2'b11 or 2'b01 after the request, or anything other than 2'b00 during the sure wait gives one cycle with `error` = 1 and `driveEn` = 0. The block then returns to idle, still not owning. `done` and `error` are never high together.
- R9: `lpxCycles` (at least 1) is read at the start of each phase and must be held stable during a sequence. A value of 1 makes each LP unit one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lpxCycles | input | LPX_W | Clock cycles per LP unit |
| startGive | input | 1 | Begin release (owner only) |
| startTake | input | 1 | Begin acquire (non-owner only) |
| lineIn | input | 2 | Sampled line state {positive, negative} |
| lineOut | output | 2 | Driven line state {positive, negative} |
| driveEn | output | 1 | Output pair is driven |
| done | output | 1 | One-cycle pulse when a handover completes |
| error | output | 1 | One-cycle pulse when an acquire aborts |

## Verification
Some rules are checked by assertions on every cycle. A driven line state may change only when the LP timer has run out. The acquire side starts driving only after a bridge sample. `done` and `error` are exclusive single-cycle pulses, an error never coincides with driving, and a freshly loaded timer is not already expired. The exact phase lengths (L, 4·L, 5·L), the sure-wait placement, the 2·L limit on the request state, the rejection of misplaced starts and each illegal-state abort can only be shown by the bench. Its scenarios replay the whole handover for several LP lengths, including a one-cycle unit.

// File: rtl/lta_pkg.sv
package lta_pkg;
  localparam logic [1:0] LINE_STOP   = 2'b11;
  localparam logic [1:0] LINE_REQ    = 2'b10;
  localparam logic [1:0] LINE_MIRROR = 2'b01;
  localparam logic [1:0] LINE_BRIDGE = 2'b00;

  localparam int UNIT_W = 3;
  localparam logic [UNIT_W-1:0] UNITS_ONE  = 3'd1;
  localparam logic [UNIT_W-1:0] UNITS_REQ  = 3'd2;
  localparam logic [UNIT_W-1:0] UNITS_GO   = 3'd4;
  localparam logic [UNIT_W-1:0] UNITS_GET  = 3'd5;

  typedef enum logic [3:0] {
    S_IDLE, S_G_STOP, S_G_REQ, S_G_BRIDGE, S_G_REL,
    S_T_WAIT, S_T_SEEREQ, S_T_SURE, S_T_BRIDGE, S_T_MARK, S_T_DONE, S_FAIL
  } ltaState_e;

  typedef struct packed {
    logic              load;
    logic [UNIT_W-1:0] units;
  } ltaStrobe_t;
endpackage

// File: rtl/lta_timer.sv
module lta_timer
  import lta_pkg::*;
#(
  parameter int LPX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LPX_W-1:0] lpxCycles,
  input  ltaStrobe_t       strb,
  output logic             expired
);
  logic [LPX_W-1:0]  cycCnt;
  logic [UNIT_W-1:0] unitCnt;
  logic [LPX_W-1:0]  cycReload;

  assign cycReload = (lpxCycles == '0) ? '0 : lpxCycles - 1'b1;
  assign expired   = (cycCnt == '0) && (unitCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycCnt  <= '0;
      unitCnt <= '0;
    end else if (strb.load) begin
      cycCnt  <= cycReload;
      unitCnt <= strb.units - 1'b1;
    end else if (!expired) begin
      if (cycCnt == '0) begin
        cycCnt  <= cycReload;
        unitCnt <= unitCnt - 1'b1;
      end else begin
        cycCnt <= cycCnt - 1'b1;
      end
    end
  end

  // R9: a phase longer than one cycle never reads as finished right after loading
  p_load_not_expired_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && lpxCycles > 1) |=> !expired);

  // R9: an expired timer stays expired until reloaded
  p_expired_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    (expired && !strb.load) |=> expired);
endmodule

// File: rtl/lta_ctrl.sv
module lta_ctrl
  import lta_pkg::*;
#(
  parameter bit OWN_AT_RESET = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startGive,
  input  logic       startTake,
  input  logic [1:0] lineIn,
  input  logic       tmrExpired,
  output ltaStrobe_t strb,
  output logic [1:0] lineOut,
  output logic       driveEn,
  output logic       done,
  output logic       error
);
  ltaState_e state, stateNxt;
  logic      ownerQ, ownerNxt;

  always_comb begin
    stateNxt   = state;
    ownerNxt   = ownerQ;
    strb.load  = 1'b0;
    strb.units = UNITS_ONE;
    unique case (state)
      S_IDLE: begin
        if (startGive && ownerQ) begin
          stateNxt  = S_G_STOP;
          strb.load = 1'b1;
        end else if (startTake && !ownerQ) begin
          stateNxt = S_T_WAIT;
        end
      end
      S_G_STOP: if (tmrExpired) begin
        stateNxt  = S_G_REQ;
        strb.load = 1'b1;
      end
      S_G_REQ: if (tmrExpired) begin
        stateNxt   = S_G_BRIDGE;
        strb.load  = 1'b1;
        strb.units = UNITS_GO;
      end
      S_G_BRIDGE: if (tmrExpired) stateNxt = S_G_REL;
      S_G_REL: begin
        stateNxt = S_IDLE;
        ownerNxt = 1'b0;
      end
      S_T_WAIT: begin
        if (lineIn == LINE_REQ) begin
          stateNxt   = S_T_SEEREQ;
          strb.load  = 1'b1;
          strb.units = UNITS_REQ;
        end else if (lineIn != LINE_STOP) begin
          stateNxt = S_FAIL;
        end
      end
      S_T_SEEREQ: begin
        if (lineIn == LINE_BRIDGE) begin
          stateNxt  = S_T_SURE;
          strb.load = 1'b1;
        end else if (lineIn != LINE_REQ || tmrExpired) begin
          stateNxt = S_FAIL;
        end
      end
      S_T_SURE: begin
        if (lineIn != LINE_BRIDGE) begin
          stateNxt = S_FAIL;
        end else if (tmrExpired) begin
          stateNxt   = S_T_BRIDGE;
          strb.load  = 1'b1;
          strb.units = UNITS_GET;
        end
      end
      S_T_BRIDGE: if (tmrExpired) begin
        stateNxt  = S_T_MARK;
        strb.load = 1'b1;
      end
      S_T_MARK: if (tmrExpired) stateNxt = S_T_DONE;
      S_T_DONE: begin
        stateNxt = S_IDLE;
        ownerNxt = 1'b1;
      end
      S_FAIL:   stateNxt = S_IDLE;
      default:  stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      ownerQ <= OWN_AT_RESET;
    end else begin
      state  <= stateNxt;
      ownerQ <= ownerNxt;
    end
  end

  always_comb begin
    lineOut = LINE_STOP;
    driveEn = 1'b0;
    done    = 1'b0;
    error   = 1'b0;
    unique case (state)
      S_IDLE:     driveEn = ownerQ;
      S_G_STOP:   driveEn = 1'b1;
      S_G_REQ:    begin driveEn = 1'b1; lineOut = LINE_REQ;    end
      S_G_BRIDGE: begin driveEn = 1'b1; lineOut = LINE_BRIDGE; end
      S_G_REL:    done = 1'b1;
      S_T_BRIDGE: begin driveEn = 1'b1; lineOut = LINE_BRIDGE; end
      S_T_MARK:   begin driveEn = 1'b1; lineOut = LINE_REQ;    end
      S_T_DONE:   begin driveEn = 1'b1; done = 1'b1;           end
      S_FAIL:     error = 1'b1;
      default:    ;
    endcase
  end

  // R2: a driven line state only steps when the LP timer has run out
  p_step_on_expiry_r2: assert property (@(posedge clk) disable iff (!rstN)
    (driveEn && $past(driveEn) && lineOut != $past(lineOut)) |-> $past(tmrExpired));

  // R5: the acquiring side starts driving the bridge only after sampling the bridge
  p_take_after_bridge_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(driveEn) && lineOut == LINE_BRIDGE) |-> $past(lineIn) == LINE_BRIDGE);

  // R3: done is a single-cycle pulse
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: an abort never drives and is followed by an idle non-driving cycle
  p_error_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    error |-> (!driveEn && !done));
  p_error_after_r8: assert property (@(posedge clk) disable iff (!rstN)
    error |=> (!error && !driveEn));

  // R6: after acquiring, the lane keeps being driven at stop
  p_keep_owner_r6: assert property (@(posedge clk) disable iff (!rstN)
    (done && driveEn) |=> (driveEn && lineOut == LINE_STOP));
endmodule

// File: rtl/lp_turnaround.sv
module lp_turnaround
  import lta_pkg::*;
#(
  parameter int LPX_W        = 8,
  parameter bit OWN_AT_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LPX_W-1:0] lpxCycles,
  input  logic             startGive,
  input  logic             startTake,
  input  logic [1:0]       lineIn,
  output logic [1:0]       lineOut,
  output logic             driveEn,
  output logic             done,
  output logic             error
);
  ltaStrobe_t tmrStrb;
  logic       tmrExpired;

  lta_ctrl #(.OWN_AT_RESET(OWN_AT_RESET)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startGive (startGive),
    .startTake (startTake),
    .lineIn    (lineIn),
    .tmrExpired(tmrExpired),
    .strb      (tmrStrb),
    .lineOut   (lineOut),
    .driveEn   (driveEn),
    .done      (done),
    .error     (error)
  );

  lta_timer #(.LPX_W(LPX_W)) u_timer (
    .clk      (clk),
    .rstN     (rstN),
    .lpxCycles(lpxCycles),
    .strb     (tmrStrb),
    .expired  (tmrExpired)
  );

  // R8: done and error never coincide
  p_done_error_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, error}));
endmodule

// File: tb/lp_turnaround_tb.sv
`timescale 1ns/1ps
module lp_turnaround_tb;
  localparam logic [1:0] ST = 2'b11, RQ = 2'b10, MI = 2'b01, BR = 2'b00;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] lpxCycles = 8'd3;
  logic       startGive = 1'b0, startTake = 1'b0;
  logic [1:0] lineIn = ST;
  logic [1:0] lineOut;
  logic       driveEn, done, error;

  int testsRun = 0, testsFailed = 0;
  bit finished = 1'b0;
  logic [4:0] expQ[$];
  string      tagQ[$];

  always #2.5 clk = ~clk;

  lp_turnaround u_dut (
    .clk(clk), .rstN(rstN), .lpxCycles(lpxCycles),
    .startGive(startGive), .startTake(startTake), .lineIn(lineIn),
    .lineOut(lineOut), .driveEn(driveEn), .done(done), .error(error)
  );

  task automatic push(input logic [1:0] l, input bit d, input bit dn, input bit er,
                      input string tag);
    expQ.push_back({l, d, dn, er});
    tagQ.push_back(tag);
  endtask

  task automatic step(input logic [1:0] li, input bit sg, input bit st);
    @(negedge clk);
    lineIn = li; startGive = sg; startTake = st;
  endtask

  // monitor: compares one expected item per clock, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [4:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        testsRun++;
        if ({lineOut, driveEn, done, error} !== e) begin
          testsFailed++;
          $display("FAIL %s: {line,drv,done,err} actual %b_%b_%b_%b expected %b_%b_%b_%b",
                   t, lineOut, driveEn, done, error, e[4:3], e[2], e[1], e[0]);
        end
      end
    end
  end

  task automatic drain();
    while (expQ.size() > 0) @(negedge clk);
  endtask

  // R2, R3: full release
  task automatic giveSeq(input int l);
    lpxCycles = l[7:0];
    for (int i = 0; i < l; i++) begin step(ST, i == 0, 0); push(ST, 1, 0, 0, "R2"); end
    for (int i = 0; i < l; i++) begin step(ST, 0, 0); push(RQ, 1, 0, 0, "R2"); end
    for (int i = 0; i < 4*l; i++) begin step(ST, 0, 0); push(BR, 1, 0, 0, "R3"); end
    step(ST, 0, 0); push(ST, 0, 1, 0, "R3");
    step(ST, 0, 0); push(ST, 0, 0, 0, "R3");
    drain();
  endtask

  // R5, R6, R7: full acquire with w extra stop samples and k request samples
  task automatic takeSeq(input int l, input int w, input int k);
    lpxCycles = l[7:0];
    step(ST, 0, 1); push(ST, 0, 0, 0, "R5");
    for (int i = 0; i < w; i++) begin step(ST, 0, 0); push(ST, 0, 0, 0, "R5"); end
    for (int i = 0; i < k; i++) begin step(RQ, 0, 0); push(ST, 0, 0, 0, "R7"); end
    for (int i = 0; i < l; i++) begin step(BR, 0, 0); push(ST, 0, 0, 0, "R5"); end
    for (int i = 0; i < 5*l; i++) begin step(BR, 0, 0); push(BR, 1, 0, 0, "R6"); end
    for (int i = 0; i < l; i++) begin step(ST, 0, 0); push(RQ, 1, 0, 0, "R6"); end
    step(ST, 0, 0); push(ST, 1, 1, 0, "R6");
    step(ST, 0, 0); push(ST, 1, 0, 0, "R6");
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testsRun++;
    if ({lineOut, driveEn, done, error} !== {ST, 3'b100}) begin
      testsFailed++;
      $display("FAIL R1: reset outputs actual %b_%b_%b_%b expected 11_1_0_0",
               lineOut, driveEn, done, error);
    end
    // R4: take ignored while owning
    step(ST, 0, 1); push(ST, 1, 0, 0, "R4");
    step(ST, 0, 0); push(ST, 1, 0, 0, "R4");
    drain();
    giveSeq(3);
    // R4: give ignored while not owning
    step(ST, 1, 0); push(ST, 0, 0, 0, "R4");
    step(ST, 0, 0); push(ST, 0, 0, 0, "R4");
    drain();
    takeSeq(3, 2, 6);          // R7 boundary: exactly 2*L request samples
    giveSeq(2);
    // R8: mirror state while waiting
    lpxCycles = 8'd2;
    step(ST, 0, 1); push(ST, 0, 0, 0, "R8");
    step(MI, 0, 0); push(ST, 0, 0, 1, "R8");
    step(ST, 0, 0); push(ST, 0, 0, 0, "R8");
    drain();
    // R7: request held one sample too long
    step(ST, 0, 1); push(ST, 0, 0, 0, "R7");
    for (int i = 0; i < 4; i++) begin step(RQ, 0, 0); push(ST, 0, 0, 0, "R7"); end
    step(RQ, 0, 0); push(ST, 0, 0, 1, "R7");
    step(ST, 0, 0); push(ST, 0, 0, 0, "R7");
    drain();
    // R8: bridge lost during sure wait
    step(ST, 0, 1); push(ST, 0, 0, 0, "R8");
    step(RQ, 0, 0); push(ST, 0, 0, 0, "R8");
    step(BR, 0, 0); push(ST, 0, 0, 0, "R8");
    step(ST, 0, 0); push(ST, 0, 0, 1, "R8");
    step(ST, 0, 0); push(ST, 0, 0, 0, "R8");
    drain();
    // R8: request skipped, bridge seen while waiting
    step(ST, 0, 1); push(ST, 0, 0, 0, "R8");
    step(BR, 0, 0); push(ST, 0, 0, 1, "R8");
    step(ST, 0, 0); push(ST, 0, 0, 0, "R8");
    drain();
    // R9: one-cycle LP unit
    takeSeq(1, 0, 1);
    giveSeq(1);
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule